// File: doc/BRIEF.md
# Video Field Line Interrupt Generator

This block is the vertical-timing event unit of one video capture channel. Software programs a single 32-bit control word through a plain register bus. The word holds two compare lines, one for each field, and each line has its own enable. The capture timing logic feeds the block a current line count, a field indicator, an end-of-line strobe and a frame-start strobe. When a line ends in a field whose enable is set, and the count equals that field's compare line, the block emits a one-cycle interrupt pulse.

The same control word also holds a field select. The select decides which field's compare line clears a sticky frame-sync status flag. The frame-start strobe sets this flag. The clear uses the stored compare line whether or not that field's interrupt is enabled. Software uses the interrupt to lock to fields, and the flag to find out whether a new frame has begun since its last synchronisation point.

The register acts only when the capture mode is one of the two embedded-sync modes. In the raw and the timing-controlled capture modes, line ends raise no interrupt and do not clear the flag.

Top module: `vline_irq_unit`

## Requirements
- R1: While reset is low, the readback word is 0, the interrupt output is 0 and the frame-sync flag is 0.
- R2: The writable fields sit at these bit positions: bit 31 is the field-2 interrupt enable, bit 30 is the clear-field select, bits 27:16 are the field-2 compare line, bit 15 is the field-1 interrupt enable and bits 11:0 are the field-1 compare line. A write is visible on the readback port in the cycle after it is presented.
- R3: Bits 29:28 and 14:12 always read 0, and a write of 1 to them leaves the readback unchanged there.
- R4: When field_id is 0 (field 1), the field-1 enable is 1 and line_cnt equals the field-1 compare line at a rising end-of-line strobe, irq_pulse is high for exactly the next cycle.
- R5: When field_id is 1 (field 2), the field-2 enable is 1 and line_cnt equals the field-2 compare line at a rising end-of-line strobe, irq_pulse is high for exactly the next cycle.
- R6: A field whose enable is 0 produces no interrupt. Any combination of the two enables is allowed.
- R7: An end-of-line strobe held high for several cycles on a matching line yields exactly one interrupt pulse.
- R8: A frame-start strobe sets the frame-sync flag in the following cycle.
- R9: With the select at 0, a matching line end in field 1 on the field-1 compare line clears the flag. With the select at 1, a matching line end in field 2 on the field-2 compare line clears it instead. Both cases hold whatever the interrupt enables are.
- R10: When a frame-start strobe and a flag-clearing line end fall in the same cycle, the flag ends up set.
- R11: cap_mode encodes 0 as BT.656, 1 as Y/C, 2 as raw and 3 as TCI. In modes 2 and 3, line ends raise no interrupt and never clear the flag.
- R12: A line end in the same cycle as a register write is compared against the register value from before the write. The new value applies from the next line end on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr_en | input | 1 | Write strobe for the control word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Current control word, reserved bits zero |
| cap_mode | input | 2 | Capture mode: 0 BT.656, 1 Y/C, 2 raw, 3 TCI |
| line_cnt | input | 12 | Current line number within the field |
| field_id | input | 1 | 0 for field 1, 1 for field 2 |
| eol_stb | input | 1 | End-of-line strobe; its rising edge is the event |
| frame_start | input | 1 | Frame-start strobe, sets the frame-sync flag |
| irq_pulse | output | 1 | One-cycle vertical interrupt |
| fsync_flag | output | 1 | Sticky frame-sync status flag |

## Verification
Every result of this block appears one clock after its cause. The interrupt pulse, the flag set, the flag clear and the register readback each pass through exactly one register stage after the edge that samples the strobe or the write. Each bench task drives its stimulus just after a falling edge, lets one rising edge pass, and samples at the following falling edge. It then drops the strobe for one idle cycle, so the next line end is again a rising edge. The frame sweep logs each line end's interrupt and flag state by line index, and compares those logs with positions computed from the enables, the select and the compare lines.

// File: rtl/vline_pkg.sv
// Package: shared field layout, types and mode decode for the vertical line
// interrupt unit. Assumes a 32-bit control word with 12-bit compare lines.
package vline_pkg;

    localparam int REG_W      = 32;
    localparam int LINE_W     = 12;
    localparam int NFIELD     = 2;

    // Bit positions of the control word (software-visible layout)
    localparam int EN2_BIT    = 31;
    localparam int SEL_BIT    = 30;
    localparam int LINE2_LSB  = 16;
    localparam int EN1_BIT    = 15;
    localparam int LINE1_LSB  = 0;

    typedef struct packed {
        logic              en2;
        logic              sel2;
        logic [LINE_W-1:0] line2;
        logic              en1;
        logic [LINE_W-1:0] line1;
    } vline_cfg_t;

    typedef enum logic [1:0] {
        MODE_BT656 = 2'd0,
        MODE_YC    = 2'd1,
        MODE_RAW   = 2'd2,
        MODE_TCI   = 2'd3
    } cap_mode_e;

    // True for the two embedded-sync capture modes where the register acts
    function automatic logic mode_active(input logic [1:0] mode);
        return (mode == MODE_BT656) || (mode == MODE_YC);
    endfunction

endpackage

// File: rtl/vline_cfg_reg.sv
// Control word storage. Captures writable fields on reg_wr_en and presents
// the word for readback with reserved positions forced to zero.
// Assumes a single-register bus: no address, write takes one cycle.
module vline_cfg_reg
    import vline_pkg::*;
#(
    parameter int RW = REG_W,
    parameter int LW = LINE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [RW-1:0] wdata,
    output vline_cfg_t    cfg,
    output logic [RW-1:0] rdata
);
    localparam int L2_MSB = LINE2_LSB + LW - 1;
    localparam int L1_MSB = LINE1_LSB + LW - 1;

    // Store writable fields, dropping reserved bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (wr_en) begin
            cfg.en2   <= wdata[EN2_BIT];
            cfg.sel2  <= wdata[SEL_BIT];
            cfg.line2 <= wdata[L2_MSB:LINE2_LSB];
            cfg.en1   <= wdata[EN1_BIT];
            cfg.line1 <= wdata[L1_MSB:LINE1_LSB];
        end
    end

    // Assemble readback word; unassigned positions stay zero
    always_comb begin
        rdata                     = '0;
        rdata[EN2_BIT]            = cfg.en2;
        rdata[SEL_BIT]            = cfg.sel2;
        rdata[L2_MSB:LINE2_LSB]   = cfg.line2;
        rdata[EN1_BIT]            = cfg.en1;
        rdata[L1_MSB:LINE1_LSB]   = cfg.line1;
    end

endmodule

// File: rtl/vline_match.sv
// Per-field line compare. Detects the rising edge of the end-of-line strobe,
// compares the line count against each field's stored line and produces a
// registered one-cycle interrupt plus a combinational flag-clear request.
// Assumes line_cnt and field_id are stable while eol_stb rises.
module vline_match
    import vline_pkg::*;
#(
    parameter int LW = LINE_W,
    parameter int NF = NFIELD
) (
    input  logic          clk,
    input  logic          rst_n,
    input  vline_cfg_t    cfg,
    input  logic [1:0]    cap_mode,
    input  logic [LW-1:0] line_cnt,
    input  logic          field_id,
    input  logic          eol_stb,
    output logic          irq_pulse,
    output logic          clr_req
);
    logic          eol_q;
    logic          eol_edge;
    logic          active;
    logic [LW-1:0] tgt_line [NF];
    logic [NF-1:0] tgt_en;
    logic [NF-1:0] hit;

    // Map stored fields onto per-field arrays
    always_comb begin
        tgt_line[0] = cfg.line1;
        tgt_line[1] = cfg.line2;
        tgt_en      = {cfg.en2, cfg.en1};
    end

    // One comparator per field
    for (genvar f = 0; f < NF; f++) begin : g_fld
        assign hit[f] = (field_id == 1'(f)) && (line_cnt == tgt_line[f]);
    end

    assign active   = mode_active(cap_mode);
    assign eol_edge = eol_stb && !eol_q;
    assign clr_req  = active && eol_edge && (cfg.sel2 ? hit[1] : hit[0]);

    // Remember strobe level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) eol_q <= 1'b0;
        else        eol_q <= eol_stb;
    end

    // Register the interrupt so it lasts exactly one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) irq_pulse <= 1'b0;
        else        irq_pulse <= active && eol_edge && |(hit & tgt_en);
    end

endmodule

// File: rtl/vline_fsync.sv
// Sticky frame-sync flag: set by the frame-start strobe, cleared by a
// clear request; a simultaneous set takes priority.
module vline_fsync (
    input  logic clk,
    input  logic rst_n,
    input  logic set_stb,
    input  logic clr_req,
    output logic flag
);
    // Update flag with set over clear priority
    always_ff @(posedge clk) begin
        if (!rst_n)       flag <= 1'b0;
        else if (set_stb) flag <= 1'b1;
        else if (clr_req) flag <= 1'b0;
    end

endmodule

// File: rtl/vline_irq_unit.sv
// Top of the vertical line interrupt unit for one capture channel. Holds the
// control word, generates field line interrupts and maintains the frame-sync
// flag. Assumes the timing inputs are synchronous to clk.
module vline_irq_unit
    import vline_pkg::*;
#(
    parameter int RW = REG_W,
    parameter int LW = LINE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr_en,
    input  logic [RW-1:0] reg_wdata,
    output logic [RW-1:0] reg_rdata,
    input  logic [1:0]    cap_mode,
    input  logic [LW-1:0] line_cnt,
    input  logic          field_id,
    input  logic          eol_stb,
    input  logic          frame_start,
    output logic          irq_pulse,
    output logic          fsync_flag
);
    vline_cfg_t cfg;
    logic       clr_req;

    vline_cfg_reg #(.RW(RW), .LW(LW)) i_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (reg_wr_en),
        .wdata (reg_wdata),
        .cfg   (cfg),
        .rdata (reg_rdata)
    );

    vline_match #(.LW(LW), .NF(NFIELD)) i_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg       (cfg),
        .cap_mode  (cap_mode),
        .line_cnt  (line_cnt),
        .field_id  (field_id),
        .eol_stb   (eol_stb),
        .irq_pulse (irq_pulse),
        .clr_req   (clr_req)
    );

    vline_fsync i_fsync (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_stb (frame_start),
        .clr_req (clr_req),
        .flag    (fsync_flag)
    );

endmodule

// File: rtl/vline_irq_chk.sv
// Checker for the vertical line interrupt unit, bound to every instance.
module vline_irq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] reg_rdata,
    input logic [1:0]  cap_mode,
    input logic        eol_stb,
    input logic        frame_start,
    input logic        irq_pulse,
    input logic        fsync_flag
);
    // Reset state
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (reg_rdata == 32'd0 && !irq_pulse && !fsync_flag));

    // Reserved positions read zero
    assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[29:28] == 2'b00 && reg_rdata[14:12] == 3'b000));

    // Interrupt follows a strobe
    assert_irq_after_eol_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> $past(eol_stb));

    // Single-cycle pulse
    assert_irq_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |=> !irq_pulse);

    // Flag sets after frame start, also when a clear coincides
    assert_fsync_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> fsync_flag);

    // Flag clears only on a line end
    assert_fsync_clear_eol_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fsync_flag) |-> $past(eol_stb));

    // Inactive modes raise nothing and clear nothing
    assert_irq_mode_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> ($past(cap_mode) == 2'd0 || $past(cap_mode) == 2'd1));

    assert_fsync_mode_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fsync_flag) |-> ($past(cap_mode) == 2'd0 || $past(cap_mode) == 2'd1));

endmodule

bind vline_irq_unit vline_irq_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_rdata   (reg_rdata),
    .cap_mode    (cap_mode),
    .eol_stb     (eol_stb),
    .frame_start (frame_start),
    .irq_pulse   (irq_pulse),
    .fsync_flag  (fsync_flag)
);

// File: tb/test_vline_irq_unit.sv
`timescale 1ns/1ps
// Directed bench for the vertical line interrupt unit.
module test_vline_irq_unit;
    localparam int N1 = 8;                    // lines in field 1
    localparam int N2 = 7;                    // lines in field 2
    localparam logic [31:0] RD_MASK = 32'hCFFF_8FFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [1:0]  cap_mode = 2'd0;
    logic [11:0] line_cnt = '0;
    logic        field_id = 1'b0;
    logic        eol_stb = 1'b0;
    logic        frame_start = 1'b0;
    logic        irq_pulse;
    logic        fsync_flag;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    vline_irq_unit i_vline_irq_unit (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .cap_mode(cap_mode), .line_cnt(line_cnt),
        .field_id(field_id), .eol_stb(eol_stb), .frame_start(frame_start),
        .irq_pulse(irq_pulse), .fsync_flag(fsync_flag)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] cfg_word(input bit en1, input bit en2, input bit sel,
                                             input int l1, input int l2);
        return {en2, sel, 2'b00, 12'(l2), en1, 3'b000, 12'(l1)};
    endfunction

    task automatic wr(input logic [31:0] d);
        reg_wr_en = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic pulse_frame();
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    // One line end: strobe for one cycle, sample results, then one idle cycle
    task automatic line_end(input int ln, input bit fld, output bit irq, output bit fs);
        line_cnt = 12'(ln); field_id = fld; eol_stb = 1'b1;
        @(negedge clk);
        irq = irq_pulse; fs = fsync_flag;
        eol_stb = 1'b0;
        @(negedge clk);
    endtask

    // Full frame sweep, checking interrupt positions and flag clear point
    task automatic run_frame(input string req, input logic [1:0] mode, input bit en1,
                             input bit en2, input bit sel, input int l1, input int l2);
        logic [31:0] got_mask = '0, exp_mask = '0;
        int got_clr = -1, exp_clr;
        bit irq, fs;
        bit act = (mode < 2'd2);
        cap_mode = mode;
        wr(cfg_word(en1, en2, sel, l1, l2));
        pulse_frame();
        chk({req, " flag set at frame start (R8)"}, 32'(fsync_flag), 32'd1);
        for (int k = 0; k < N1 + N2; k++) begin
            bit fld = (k >= N1);
            int ln = fld ? k - N1 : k;
            line_end(ln, fld, irq, fs);
            if (irq) got_mask[k] = 1'b1;
            if (!fs && got_clr < 0) got_clr = k;
        end
        if (act && en1) exp_mask[l1] = 1'b1;
        if (act && en2) exp_mask[N1 + l2] = 1'b1;
        exp_clr = !act ? -1 : (sel ? N1 + l2 : l1);
        chk({req, " interrupt positions"}, got_mask, exp_mask);
        chk({req, " flag clear line"}, 32'(got_clr), 32'(exp_clr));
        cap_mode = 2'd0;
    endtask

    task automatic t_reset();
        chk("R1 reset rdata", reg_rdata, 32'd0);
        chk("R1 reset irq", 32'(irq_pulse), 32'd0);
        chk("R1 reset flag", 32'(fsync_flag), 32'd0);
    endtask

    task automatic t_register();
        wr(32'hFFFF_FFFF);
        chk("R3 reserved bits after all-ones write", reg_rdata, RD_MASK);
        wr(32'h8ABC_8123);
        chk("R2 R3 field layout readback", reg_rdata, 32'h8ABC_8123 & RD_MASK);
        wr(cfg_word(1'b0, 1'b1, 1'b1, 12'hFFF, 12'h001));
        chk("R2 field pack", reg_rdata, 32'hC001_0FFF);
        wr(32'd0);
    endtask

    task automatic t_sweep();
        for (int c = 0; c < 8; c++) begin
            run_frame($sformatf("R4 R5 R6 R9 combo%0d", c), 2'd0, c[0], c[1], c[2], 3, 5);
        end
        run_frame("R11 Y/C active", 2'd1, 1'b1, 1'b1, 1'b0, 0, 6);
        run_frame("R11 raw inactive", 2'd2, 1'b1, 1'b1, 1'b0, 2, 2);
        run_frame("R11 TCI inactive", 2'd3, 1'b1, 1'b1, 1'b1, 2, 2);
    endtask

    task automatic t_hold();
        int cnt = 0;
        wr(cfg_word(1'b1, 1'b0, 1'b0, 2, 0));
        line_cnt = 12'd2; field_id = 1'b0; eol_stb = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (irq_pulse) cnt++;
        end
        eol_stb = 1'b0;
        @(negedge clk);
        if (irq_pulse) cnt++;
        chk("R7 held strobe gives one pulse", 32'(cnt), 32'd1);
    endtask

    task automatic t_set_wins();
        bit irq, fs;
        wr(cfg_word(1'b0, 1'b0, 1'b0, 4, 0));
        pulse_frame();
        line_cnt = 12'd4; field_id = 1'b0; eol_stb = 1'b1; frame_start = 1'b1;
        @(negedge clk);
        chk("R10 set wins over clear", 32'(fsync_flag), 32'd1);
        chk("R6 disabled field no irq", 32'(irq_pulse), 32'd0);
        eol_stb = 1'b0; frame_start = 1'b0;
        @(negedge clk);
        line_end(4, 1'b0, irq, fs);
        chk("R9 clear with enable off", 32'(fs), 32'd0);
    endtask

    task automatic t_write_timing();
        bit irq, fs;
        wr(cfg_word(1'b1, 1'b0, 1'b0, 5, 0));
        line_cnt = 12'd5; field_id = 1'b0; eol_stb = 1'b1;
        reg_wr_en = 1'b1; reg_wdata = cfg_word(1'b1, 1'b0, 1'b0, 6, 0);
        @(negedge clk);
        reg_wr_en = 1'b0; eol_stb = 1'b0;
        chk("R12 compare uses old value", 32'(irq_pulse), 32'd1);
        @(negedge clk);
        line_end(5, 1'b0, irq, fs);
        chk("R12 old line no longer matches", 32'(irq), 32'd0);
        line_end(6, 1'b0, irq, fs);
        chk("R12 new line matches", 32'(irq), 32'd1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_register();
        t_sweep();
        t_hold();
        t_set_wins();
        t_write_timing();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule